// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-word burst. A burst begins when the controller presents a start address with the load/advance input low and the select-valid input high. The block then shows that address on its output. On each later cycle that carries an advance request, it steps the two low address bits to the next beat. The upper address bits stay as they were at load. After the fourth beat the next advance returns the low bits to the starting offset. No carry ever reaches the upper bits.

A static mode input picks one of two beat orders. In linear order the low bits count up modulo four from the starting offset. In interleaved order beat k uses the starting offset XOR k. A load cycle with select-valid low ends any burst in progress. An advance request outside a burst does nothing. While the stall input is high, the block ignores all its synchronous inputs and its outputs hold. The output address comes straight from registers, so it is valid the cycle after the load or advance that produced it.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, `active_o` is 0 and `addr_o` is all zeros.
- R2: A clocked cycle with `stall_i`=0, `adv_i`=0 and `sel_i`=1 loads `base_addr_i`. From the next cycle `addr_o` equals that address and `active_o` is 1. This also applies when a burst is already running, which restarts it.
- R3: With `order_i`=0 (linear), the low two bits of beat k are (start + k) mod 4. Example: start 1 gives 1,2,3,0.
- R4: With `order_i`=1 (interleaved), the low two bits of beat k are start XOR k. Example: start 1 gives 1,0,3,2.
- R5: The advance that follows the fourth beat returns the low bits to the starting offset. Bits above bit 1 never change during a burst, even when the low bits wrap from 3 to 0.
- R6: When `adv_i`=1, the value on `base_addr_i` has no effect on `addr_o`.
- R7: A clocked cycle with `stall_i`=0, `adv_i`=0 and `sel_i`=0 clears `active_o` on the next cycle and leaves `addr_o` unchanged.
- R8: While `stall_i`=1, `addr_o` and `active_o` keep their values whatever the other inputs do.
- R9: An advance request (`adv_i`=1, `stall_i`=0) while `active_o`=0 leaves `active_o` and `addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| stall_i | input | 1 | High freezes the sequencer; all other synchronous inputs are ignored |
| adv_i | input | 1 | 0 = load (or terminate when deselected), 1 = advance to the next beat |
| sel_i | input | 1 | Device selected; qualifies a load |
| order_i | input | 1 | Static burst order: 0 = linear, 1 = interleaved |
| base_addr_i | input | ADDR_W | Start address for a new burst |
| addr_o | output | ADDR_W | Address of the current beat |
| active_o | output | 1 | A burst is in progress |

## Verification
The hardest case to reach from the ports is a burst whose upper address bits sit just below a carry boundary, with a start offset of 3. Here a wrong counter would leak a carry upward. The stimulus loads an address ending in hex FFFF in both orders and steps through the wrap. It also places a stall and a deselect in the middle of an interleaved burst, with garbage on the address input. This shows that the address holds and that the following idle advance does not revive the burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned BEAT_W    = $clog2(BURST_LEN);

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

  // Offset of a beat given the starting offset and the beat index.
  function automatic beat_t beat_offset(input beat_t start, input beat_t idx, input order_e ord);
    beat_t res;
    if (ord == ORDER_INTERLEAVE) res = start ^ idx;
    else                         res = start + idx;
    return res;
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  kill_i,
  input  logic  step_i,
  output logic  active_o,
  output beat_t beat_o
);

  logic  active_d, active_q;
  beat_t beat_d, beat_q;

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    if (load_i) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (kill_i) begin
      active_d = 1'b0;
    end else if (step_i) begin
      beat_d   = beat_q + beat_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i && !kill_i |=> beat_o == beat_t'($past(beat_o) + beat_t'(1))); // R3

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> active_o && beat_o == '0); // R2

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_pkg::*;
(
  input  beat_t start_i,
  input  beat_t beat_i,
  input  logic  order_i,
  output beat_t offset_o
);

  assign offset_o = beat_offset(start_i, beat_i, order_e'(order_i));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              adv_i,
  input  logic              sel_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              active_o
);

  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  // Reset: asserted asynchronously, released through a synchronizer chain.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // Control decode; clock enable written out.
  logic ce;
  logic load_go, kill_go, step_go;

  assign ce      = ~stall_i;
  assign load_go = ce & ~adv_i &  sel_i;
  assign kill_go = ce & ~adv_i & ~sel_i;
  assign step_go = ce &  adv_i & active_o;

  // Captured start address.
  logic [HI_W-1:0] hi_d, hi_q;
  beat_t           start_d, start_q;

  always_comb begin
    hi_d    = hi_q;
    start_d = start_q;
    if (load_go) begin
      hi_d    = base_addr_i[ADDR_W-1:BEAT_W];
      start_d = base_addr_i[BEAT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hi_q    <= '0;
      start_q <= '0;
    end else begin
      hi_q    <= hi_d;
      start_q <= start_d;
    end
  end

  beat_t beat;
  beat_t offset;

  burst_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (load_go),
    .kill_i   (kill_go),
    .step_i   (step_go),
    .active_o (active_o),
    .beat_o   (beat)
  );

  burst_offset_map u_map (
    .start_i  (start_q),
    .beat_i   (beat),
    .order_i  (order_i),
    .offset_o (offset)
  );

  assign addr_o = {hi_q, offset};

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_int_n)
    !stall_i && !adv_i && sel_i |=> active_o && addr_o == $past(base_addr_i)); // R2

  AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_int_n)
    !stall_i && adv_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])); // R5

  AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !stall_i && !adv_i && !sel_i |=> !active_o && $stable(addr_o)); // R7

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_int_n)
    stall_i |=> $stable(addr_o) && $stable(active_o)); // R8

  AST_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_int_n)
    !stall_i && adv_i && !active_o |=> !active_o && $stable(addr_o)); // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_int_n |-> !active_o && addr_o == '0); // R1

endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 20;
  localparam int NVEC       = 24;
  localparam int VW         = 4 + 4 + AW + AW + 1;

  logic          clk;
  logic          rst_n;
  logic          stall_i, adv_i, sel_i, order_i;
  logic [AW-1:0] base_addr_i;
  logic [AW-1:0] addr_o;
  logic          active_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_i     (stall_i),
    .adv_i       (adv_i),
    .sel_i       (sel_i),
    .order_i     (order_i),
    .base_addr_i (base_addr_i),
    .addr_o      (addr_o),
    .active_o    (active_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Vector: {req(4), stall, adv, sel, order, base, exp_addr, exp_active}
  localparam logic [VW-1:0] VECS [0:NVEC-1] = '{
    {4'd2, 4'b0010, 20'h12341, 20'h12341, 1'b1}, // R2 load linear start 1
    {4'd6, 4'b0100, 20'hFFFF0, 20'h12342, 1'b1}, // R6 R3 base ignored
    {4'd3, 4'b0100, 20'h00000, 20'h12343, 1'b1}, // R3
    {4'd3, 4'b0100, 20'h00000, 20'h12340, 1'b1}, // R3 wrap 3->0
    {4'd5, 4'b0100, 20'h00000, 20'h12341, 1'b1}, // R5 back to start
    {4'd2, 4'b0011, 20'h5A5A5, 20'h5A5A5, 1'b1}, // R2 load interleaved start 1
    {4'd4, 4'b0101, 20'h00000, 20'h5A5A4, 1'b1}, // R4
    {4'd4, 4'b0101, 20'h00000, 20'h5A5A7, 1'b1}, // R4
    {4'd4, 4'b0101, 20'h00000, 20'h5A5A6, 1'b1}, // R4
    {4'd5, 4'b0101, 20'h00000, 20'h5A5A5, 1'b1}, // R5 wrap to start
    {4'd8, 4'b1011, 20'h00000, 20'h5A5A5, 1'b1}, // R8 stalled load ignored
    {4'd4, 4'b0101, 20'h00000, 20'h5A5A4, 1'b1}, // R4 resumes
    {4'd7, 4'b0001, 20'h11111, 20'h5A5A4, 1'b0}, // R7 deselect ends burst
    {4'd9, 4'b0101, 20'h22222, 20'h5A5A4, 1'b0}, // R9 idle advance
    {4'd2, 4'b0011, 20'h0FFFF, 20'h0FFFF, 1'b1}, // R2 interleaved start 3
    {4'd4, 4'b0101, 20'h00000, 20'h0FFFE, 1'b1}, // R4
    {4'd4, 4'b0101, 20'h00000, 20'h0FFFD, 1'b1}, // R4
    {4'd4, 4'b0101, 20'h00000, 20'h0FFFC, 1'b1}, // R4
    {4'd2, 4'b0010, 20'h0FFFF, 20'h0FFFF, 1'b1}, // R2 linear start 3
    {4'd5, 4'b0100, 20'h00000, 20'h0FFFC, 1'b1}, // R5 no carry upward
    {4'd3, 4'b0100, 20'h00000, 20'h0FFFD, 1'b1}, // R3
    {4'd8, 4'b1100, 20'h33333, 20'h0FFFD, 1'b1}, // R8 stalled advance
    {4'd2, 4'b0010, 20'hABCD2, 20'hABCD2, 1'b1}, // R2 restart mid-burst
    {4'd3, 4'b0100, 20'h00000, 20'hABCD3, 1'b1}  // R3
  };

  task automatic check(input string req, input logic [AW-1:0] exp_a, input logic exp_v);
    n_checks++;
    if (addr_o !== exp_a || active_o !== exp_v) begin
      n_fail++;
      $display("FAIL %s: addr=%h active=%b expected addr=%h active=%b",
               req, addr_o, active_o, exp_a, exp_v);
    end
  endtask

  task automatic drive(input logic s, input logic a, input logic e, input logic o,
                       input logic [AW-1:0] b);
    stall_i = s; adv_i = a; sel_i = e; order_i = o; base_addr_i = b;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0);
    repeat (3) @(negedge clk);
    check("R1 in reset", '0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", '0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      drive(v[44], v[43], v[42], v[41], v[40:21]);
      @(negedge clk);
      check($sformatf("R%0d vec %0d", v[48:45], i), v[20:1], v[0]);
    end

    // R1: reset asserted mid-burst clears at once
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0);
    #1 rst_n = 1'b0;
    #1 check("R1 mid-burst reset", '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: advance right after reset stays idle
    check("R9 advance after reset", '0, 1'b0);
    // R7: deselect-load while idle keeps idle
    drive(1'b0, 1'b0, 1'b0, 1'b1, 20'h77777);
    @(negedge clk);
    check("R7 deselect while idle", '0, 1'b0);
    // R4: interleaved start 2 -> 2,3,0,1
    drive(1'b0, 1'b0, 1'b1, 1'b1, 20'h00006);
    @(negedge clk);
    check("R4 start 2 beat0", 20'h00006, 1'b1);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 20'hFFFFF);
    @(negedge clk);
    check("R4 start 2 beat1", 20'h00007, 1'b1);
    @(negedge clk);
    check("R4 start 2 beat2", 20'h00004, 1'b1);
    @(negedge clk);
    check("R4 start 2 beat3", 20'h00005, 1'b1);
    @(negedge clk);
    check("R5 start 2 wrap", 20'h00006, 1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule